// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps wall-clock time and calendar date in packed BCD registers: seconds, minutes, hours in 24-hour form, day of month, weekday, month and a two-digit year covering 2000 to 2099. A free-running prescaler counts enable pulses from a 32.768 kHz reference and produces one tick per second. Each tick moves the calendar forward, with carries running from seconds up to the year. Month lengths and leap years are handled.

Software reaches the registers through a byte-wide bus. The address selects a register, a write strobe stores a byte, and the read data follows the address combinationally. Setting a stop bit in the control register holds the prescaler at zero, so software can load a new time and then release counting on an exact second boundary. While the host holds `burstRd` high during a multi-byte read, ticks do not change the visible registers. One tick that arrives in that window is remembered and applied as soon as the read ends, so the bytes read stay consistent and no second is lost. Bit 7 of the seconds register flags that the oscillator stopped, and it is set at reset.

Top module: `bcd_calendar`

## Requirements
- R1: After reset, control (address 0x0) reads 0x00. Seconds (0x4) reads 0x80, meaning the oscillator-stop flag is set and the count is zero. Minutes (0x5), hours (0x6), weekday (0x8) and year (0xA) read 0x00. Day (0x7) and month (0x9) read 0x01.
- R2: A one-second tick happens on the PRESC_DIV-th `refEn` pulse counted since the prescaler was last cleared. Each tick adds one to the BCD seconds, so 0x09 becomes 0x10. Clock cycles without `refEn` do not count.
- R3: On a tick, seconds roll from 0x59 to 0x00 and carry into minutes. Minutes roll from 0x59 to 0x00 and carry into hours. Hours roll from 0x23 to 0x00 and move the day and the weekday on by one.
- R4: The day rolls to 0x01 and the month advances after the last day of the month. Months 0x04, 0x06, 0x09 and 0x11 have 30 days, and the other months have 31. February has 28 days, or 29 when the BCD year is divisible by 4 (year 0x00 counts as a leap year).
- R5: After 31 December the month goes from 0x12 to 0x01 and the year advances in BCD. The year wraps from 0x99 to 0x00.
- R6: The weekday at address 0x8 is a 3-bit binary value. On a day change it wraps from 6 to 0.
- R7: Bit 7 of the seconds register is the oscillator-stop flag. A write to seconds loads the flag from bit 7 of the written byte, so writing bit 7 = 0 clears it.
- R8: The stop bit is bit 5 of the control register at address 0x0. While it is 1, no tick occurs and the prescaler is held at zero. After it is cleared, the first tick comes on exactly the PRESC_DIV-th `refEn` pulse.
- R9: While `burstRd` is 1, ticks do not change any time register. One tick that falls inside that window is applied on the first clock edge after `burstRd` returns to 0. The prescaler keeps counting throughout the window.
- R10: A write to a time register takes effect on the next clock edge and leaves the prescaler count unchanged. If a write and a tick land on the same edge, the written field takes the written value. The other fields advance, with carries taken from the values held before that edge.
- R11: Bits above each field's width read 0. The field widths are: minutes 7 bits, hours 6, day 6, weekday 3, month 5. In the control register only bit 5 is stored. Addresses 0x1–0x3 and 0xB–0xF read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refEn | input | 1 | One-cycle enable per 32.768 kHz reference period |
| regAddr | input | ADDR_W | Register address |
| regWr | input | 1 | Write strobe |
| regWrData | input | 8 | Write data |
| burstRd | input | 1 | High while a multi-byte time read is in progress |
| regRdData | output | 8 | Read data for `regAddr` (combinational) |

## Verification
Three pairs of events can fall on the same clock edge. A bus write and a second tick can coincide. The end of a burst read can release a deferred tick. A fresh tick can arrive while a deferred one is still waiting. The bench brings the prescaler to one pulse short of a tick and then drives `refEn` in the same cycle as a write to minutes, and in another case as a write to seconds. It expects the written field to hold its written value while the other fields advance, with the carry taken from the old seconds. For the burst case it counts pulses across the window. It then checks that exactly one second is applied on the edge after `burstRd` falls, and that the next tick arrives on its normal prescaler schedule.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int DATA_W     = 8;
  localparam int NUM_FIELDS = 7;
  localparam int TIME_BASE  = 4;   // first time register address
  localparam int STOP_BIT   = 5;   // position of stop in control byte

  // strobes handed from control to datapath
  typedef struct packed {
    logic                  advance;   // apply one second this edge
    logic [NUM_FIELDS-1:0] wrField;   // one-hot: 0 sec .. 6 year
    logic [DATA_W-1:0]     wrData;
  } cal_strobe_t;

  // add one to a two-digit BCD value
  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // BCD year divisible by four
  function automatic logic isLeap(input logic [7:0] yr);
    logic [3:0] ones;
    ones = yr[3:0];
    if (!yr[4]) return (ones == 4'd0) || (ones == 4'd4) || (ones == 4'd8);
    else        return (ones == 4'd2) || (ones == 4'd6);
  endfunction

  // last day of a month, BCD
  function automatic logic [5:0] lastDay(input logic [4:0] mon, input logic [7:0] yr);
    case (mon)
      5'h02:                      return isLeap(yr) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import cal_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int PRESC_DIV = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              refEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              burstRd,
  output cal_strobe_t       st,
  output logic              stopBit
);

  localparam int             PW   = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam logic [PW-1:0]  PMAX = PW'(PRESC_DIV - 1);

  logic [PW-1:0] prescCnt;
  logic          pendingTick;
  logic          tickNow;
  logic          ctrlWr;

  assign ctrlWr  = regWr && (regAddr == ADDR_W'(0));
  assign tickNow = refEn && !stopBit && (prescCnt == PMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          prescCnt <= '0;
    else if (stopBit)    prescCnt <= '0;
    else if (refEn)      prescCnt <= tickNow ? '0 : prescCnt + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stopBit <= 1'b0;
    else if (ctrlWr) stopBit <= regWrData[STOP_BIT];
  end

  // one deferred second: kept while reading, or when a new tick
  // coincides with the release of an older one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pendingTick <= 1'b0;
    else if (stopBit) pendingTick <= 1'b0;
    else if (burstRd) pendingTick <= pendingTick | tickNow;
    else              pendingTick <= pendingTick & tickNow;
  end

  assign st.advance = !stopBit && !burstRd && (tickNow || pendingTick);
  assign st.wrData  = regWrData;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_dec
    assign st.wrField[i] = regWr && (regAddr == ADDR_W'(TIME_BASE + i));
  end

  // R8: no second may advance while stopped
  a_r8_stop_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    stopBit |-> !st.advance);

  // R9: a held-over second is released as soon as the read ends
  a_r9_pending_released: assert property (@(posedge clk) disable iff (!rst_n)
    (pendingTick && !burstRd && !stopBit) |-> st.advance);

  // R2: prescaler stays inside its period
  a_r2_presc_bound: assert property (@(posedge clk) disable iff (!rst_n)
    prescCnt <= PMAX);

endmodule

// File: rtl/cal_datapath.sv
module cal_datapath
  import cal_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cal_strobe_t       st,
  input  logic              stopBit,
  input  logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regRdData
);

  logic [6:0] secR, minR;
  logic [5:0] hrR, dayR;
  logic [2:0] wdayR;
  logic [4:0] monR;
  logic [7:0] yrR;
  logic       osFlag;

  logic secRoll, minRoll, hrRoll, dayRoll, monRoll;
  logic [7:0] incSec, incMin, incHr, incDay, incMon, incYr;

  assign incSec = bcdInc({1'b0, secR});
  assign incMin = bcdInc({1'b0, minR});
  assign incHr  = bcdInc({2'b0, hrR});
  assign incDay = bcdInc({2'b0, dayR});
  assign incMon = bcdInc({3'b0, monR});
  assign incYr  = bcdInc(yrR);

  assign secRoll = (secR == 7'h59);
  assign minRoll = secRoll && (minR == 7'h59);
  assign hrRoll  = minRoll && (hrR == 6'h23);
  assign dayRoll = hrRoll && (dayR == lastDay(monR, yrR));
  assign monRoll = dayRoll && (monR == 5'h12);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secR   <= '0;
      minR   <= '0;
      hrR    <= '0;
      dayR   <= 6'h01;
      wdayR  <= '0;
      monR   <= 5'h01;
      yrR    <= '0;
      osFlag <= 1'b1;
    end else begin
      if (st.wrField[0]) begin
        secR   <= st.wrData[6:0];
        osFlag <= st.wrData[7];
      end else if (st.advance) begin
        secR   <= secRoll ? 7'h00 : incSec[6:0];
      end

      if (st.wrField[1])                 minR <= st.wrData[6:0];
      else if (st.advance && secRoll)    minR <= minRoll ? 7'h00 : incMin[6:0];

      if (st.wrField[2])                 hrR <= st.wrData[5:0];
      else if (st.advance && minRoll)    hrR <= hrRoll ? 6'h00 : incHr[5:0];

      if (st.wrField[3])                 dayR <= st.wrData[5:0];
      else if (st.advance && hrRoll)     dayR <= dayRoll ? 6'h01 : incDay[5:0];

      if (st.wrField[4])                 wdayR <= st.wrData[2:0];
      else if (st.advance && hrRoll)     wdayR <= (wdayR >= 3'd6) ? 3'd0 : wdayR + 3'd1;

      if (st.wrField[5])                 monR <= st.wrData[4:0];
      else if (st.advance && dayRoll)    monR <= monRoll ? 5'h01 : incMon[4:0];

      if (st.wrField[6])                 yrR <= st.wrData;
      else if (st.advance && monRoll)    yrR <= (yrR == 8'h99) ? 8'h00 : incYr;
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_W'(0):             regRdData = 8'(stopBit) << STOP_BIT;
      ADDR_W'(TIME_BASE + 0): regRdData = {osFlag, secR};
      ADDR_W'(TIME_BASE + 1): regRdData = {1'b0, minR};
      ADDR_W'(TIME_BASE + 2): regRdData = {2'b0, hrR};
      ADDR_W'(TIME_BASE + 3): regRdData = {2'b0, dayR};
      ADDR_W'(TIME_BASE + 4): regRdData = {5'b0, wdayR};
      ADDR_W'(TIME_BASE + 5): regRdData = {3'b0, monR};
      ADDR_W'(TIME_BASE + 6): regRdData = yrR;
      default:                regRdData = '0;
    endcase
  end

  // R9/R10: without a strobe the calendar holds still
  a_r9_frozen_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!st.advance && (st.wrField == '0)) |=> $stable({secR, minR, hrR, dayR, wdayR, monR, yrR}));

  // R3: seconds wrap to zero
  a_r3_sec_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (st.advance && !st.wrField[0] && secR == 7'h59) |=> (secR == 7'h00));

  // R5: year wraps on the last second of 2099
  a_r5_year_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (st.advance && monRoll && !st.wrField[6] && yrR == 8'h99) |=> (yrR == 8'h00));

  // R6: weekday leaves 6 only towards 0
  a_r6_wday_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (st.advance && hrRoll && !st.wrField[4] && wdayR == 3'd6) |=> (wdayR == 3'd0));

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int PRESC_DIV = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              refEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [7:0]        regWrData,
  input  logic              burstRd,
  output logic [7:0]        regRdData
);

  cal_strobe_t st;
  logic        stopBit;

  cal_ctrl #(.ADDR_W(ADDR_W), .PRESC_DIV(PRESC_DIV)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .refEn     (refEn),
    .regAddr   (regAddr),
    .regWr     (regWr),
    .regWrData (regWrData),
    .burstRd   (burstRd),
    .st        (st),
    .stopBit   (stopBit)
  );

  cal_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .stopBit   (stopBit),
    .regAddr   (regAddr),
    .regRdData (regRdData)
  );

endmodule

// File: tb/sim_bcd_calendar.sv
module sim_bcd_calendar;

  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       refEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic       regWr = 1'b0;
  logic [7:0] regWrData = '0;
  logic       burstRd = 1'b0;
  logic [7:0] regRdData;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  bcd_calendar #(.ADDR_W(4), .PRESC_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .refEn(refEn), .regAddr(regAddr),
    .regWr(regWr), .regWrData(regWrData), .burstRd(burstRd),
    .regRdData(regRdData)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wrReg(input logic [3:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [3:0] a, output logic [7:0] v);
    regAddr = a;
    #1 v = regRdData;
  endtask

  task automatic expectReg(input string tag, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rdReg(a, v);
    check(tag, v, exp);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      refEn = 1'b1;
      @(negedge clk);
    end
    refEn = 1'b0;
  endtask

  task automatic setTime(input logic [7:0] s, mi, h, d, w, mo, y);
    wrReg(4'h0, 8'h20);
    wrReg(4'h4, s); wrReg(4'h5, mi); wrReg(4'h6, h); wrReg(4'h7, d);
    wrReg(4'h8, w); wrReg(4'h9, mo); wrReg(4'hA, y);
    wrReg(4'h0, 8'h00);
  endtask

  task automatic t_reset;
    expectReg("R1 ctrl", 4'h0, 8'h00);
    expectReg("R1 sec+flag", 4'h4, 8'h80);
    expectReg("R1 min", 4'h5, 8'h00);
    expectReg("R1 hour", 4'h6, 8'h00);
    expectReg("R1 day", 4'h7, 8'h01);
    expectReg("R1 wday", 4'h8, 8'h00);
    expectReg("R1 month", 4'h9, 8'h01);
    expectReg("R1 year", 4'hA, 8'h00);
  endtask

  task automatic t_tick;
    setTime(8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00);
    expectReg("R7 flag cleared", 4'h4, 8'h00);
    pulses(DIV - 1);
    expectReg("R2 before tick", 4'h4, 8'h00);
    pulses(1);
    expectReg("R2 first tick", 4'h4, 8'h01);
    repeat (10) @(negedge clk);
    expectReg("R2 idle no count", 4'h4, 8'h01);
    pulses(DIV * 9);
    expectReg("R2 bcd carry", 4'h4, 8'h10);
    wrReg(4'h4, 8'h95);
    expectReg("R7 flag loaded", 4'h4, 8'h95);
  endtask

  task automatic rollDay(input string tag, input logic [7:0] d, w, mo, y,
                         input logic [7:0] ed, ew, emo, ey);
    setTime(8'h59, 8'h59, 8'h23, d, w, mo, y);
    pulses(DIV);
    expectReg({tag, " day"}, 4'h7, ed);
    expectReg({tag, " wday"}, 4'h8, ew);
    expectReg({tag, " month"}, 4'h9, emo);
    expectReg({tag, " year"}, 4'hA, ey);
  endtask

  task automatic t_roll;
    setTime(8'h59, 8'h59, 8'h23, 8'h15, 8'h03, 8'h06, 8'h24);
    pulses(DIV);
    expectReg("R3 sec", 4'h4, 8'h00);
    expectReg("R3 min", 4'h5, 8'h00);
    expectReg("R3 hour", 4'h6, 8'h00);
    expectReg("R3 day", 4'h7, 8'h16);
    expectReg("R3 wday", 4'h8, 8'h04);
    setTime(8'h59, 8'h14, 8'h09, 8'h15, 8'h03, 8'h06, 8'h24);
    pulses(DIV);
    expectReg("R3 min carry", 4'h5, 8'h15);
    expectReg("R3 hour kept", 4'h6, 8'h09);
  endtask

  task automatic t_month;
    rollDay("R4 30-day", 8'h30, 8'h01, 8'h04, 8'h23, 8'h01, 8'h02, 8'h05, 8'h23);
    rollDay("R4 31-day", 8'h30, 8'h01, 8'h01, 8'h23, 8'h31, 8'h02, 8'h01, 8'h23);
    rollDay("R4 feb common", 8'h28, 8'h01, 8'h02, 8'h23, 8'h01, 8'h02, 8'h03, 8'h23);
    rollDay("R4 feb leap 24", 8'h28, 8'h01, 8'h02, 8'h24, 8'h29, 8'h02, 8'h02, 8'h24);
    rollDay("R4 feb leap 12", 8'h28, 8'h01, 8'h02, 8'h12, 8'h29, 8'h02, 8'h02, 8'h12);
    rollDay("R4 feb leap 00", 8'h29, 8'h01, 8'h02, 8'h00, 8'h01, 8'h02, 8'h03, 8'h00);
    rollDay("R5 dec 99", 8'h31, 8'h05, 8'h12, 8'h99, 8'h01, 8'h06, 8'h01, 8'h00);
    rollDay("R5 dec 19", 8'h31, 8'h05, 8'h12, 8'h19, 8'h01, 8'h06, 8'h01, 8'h20);
    rollDay("R6 wday wrap", 8'h10, 8'h06, 8'h07, 8'h19, 8'h11, 8'h00, 8'h07, 8'h19);
  endtask

  task automatic t_stop;
    setTime(8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00);
    wrReg(4'h0, 8'h20);
    expectReg("R8 ctrl reads stop", 4'h0, 8'h20);
    pulses(DIV * 3);
    expectReg("R8 no tick while stopped", 4'h4, 8'h00);
    wrReg(4'h0, 8'h00);
    pulses(DIV - 2);
    wrReg(4'h0, 8'h20);
    wrReg(4'h0, 8'h00);
    pulses(DIV - 1);
    expectReg("R8 prescaler cleared", 4'h4, 8'h00);
    pulses(1);
    expectReg("R8 exact boundary", 4'h4, 8'h01);
  endtask

  task automatic t_burst;
    setTime(8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00);
    burstRd = 1'b1;
    pulses(DIV);
    expectReg("R9 frozen at tick", 4'h4, 8'h00);
    pulses(2);
    expectReg("R9 still frozen", 4'h4, 8'h00);
    burstRd = 1'b0;
    #1;
    check("R9 not yet applied", regRdData, 8'h00);
    @(negedge clk);
    expectReg("R9 deferred applied", 4'h4, 8'h01);
    pulses(DIV - 3);
    expectReg("R9 no double", 4'h4, 8'h01);
    pulses(1);
    expectReg("R9 schedule kept", 4'h4, 8'h02);
  endtask

  task automatic t_write;
    setTime(8'h10, 8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00);
    pulses(2);
    wrReg(4'h4, 8'h30);
    pulses(DIV - 2);
    expectReg("R10 prescaler kept", 4'h4, 8'h31);

    setTime(8'h59, 8'h05, 8'h07, 8'h01, 8'h00, 8'h01, 8'h00);
    pulses(DIV - 1);
    refEn = 1'b1; regAddr = 4'h5; regWrData = 8'h40; regWr = 1'b1;
    @(negedge clk);
    refEn = 1'b0; regWr = 1'b0;
    expectReg("R10 tick with min write sec", 4'h4, 8'h00);
    expectReg("R10 min write wins", 4'h5, 8'h40);
    expectReg("R10 hour untouched", 4'h6, 8'h07);

    setTime(8'h59, 8'h05, 8'h07, 8'h01, 8'h00, 8'h01, 8'h00);
    pulses(DIV - 1);
    refEn = 1'b1; regAddr = 4'h4; regWrData = 8'h20; regWr = 1'b1;
    @(negedge clk);
    refEn = 1'b0; regWr = 1'b0;
    expectReg("R10 sec write wins", 4'h4, 8'h20);
    expectReg("R10 old-sec carry", 4'h5, 8'h06);
  endtask

  task automatic t_width;
    wrReg(4'h5, 8'hFF); expectReg("R11 min width", 4'h5, 8'h7F);
    wrReg(4'h6, 8'hE3); expectReg("R11 hour width", 4'h6, 8'h23);
    wrReg(4'h9, 8'hF1); expectReg("R11 month width", 4'h9, 8'h11);
    wrReg(4'h8, 8'hFE); expectReg("R11 wday width", 4'h8, 8'h06);
    wrReg(4'h0, 8'hFF); expectReg("R11 ctrl only stop", 4'h0, 8'h20);
    wrReg(4'h0, 8'h00);
    wrReg(4'h4, 8'h42);
    wrReg(4'h2, 8'h55); expectReg("R11 unmapped 2 reads 0", 4'h2, 8'h00);
    wrReg(4'hC, 8'h33); expectReg("R11 unmapped C reads 0", 4'hC, 8'h00);
    expectReg("R11 sec untouched", 4'h4, 8'h42);
    expectReg("R11 year untouched", 4'hA, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tick();
    t_roll();
    t_month();
    t_stop();
    t_burst();
    t_write();
    t_width();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule